// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block collects interrupt requests from peripherals into numbered groups and presents the most urgent one to the processor. Group 0 is reserved for three non-maskable sources. Groups 2 to NUM_GRP-1 are maskable, and there is no group 1. Each maskable group has a control register with four fields: a 3-bit priority level, an enable bit, a latched request bit and a read-only detect bit. A group takes part in arbitration only while its detect bit is set.

The controller also holds the processor's global interrupt-enable flag and its 3-bit mask level. Level 0 is the most urgent. A maskable group is signalled only when the global enable is set and the group's level is strictly below the mask. A latched non-maskable source is always signalled. The processor loads the flags through a flag write port. When it acknowledges a signalled interrupt, the global enable clears, and software sets it again to allow nesting.

Software reaches the group registers over a simple bus with byte lanes. Each register is a 16-bit value at a word-spaced offset starting at BASE_ADDR.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, the global enable is 0, the mask is 0, every group register reads 0 and irq_valid_o is 0.
- R2: Group n (n = 0 or 2..NUM_GRP-1) sits at byte address BASE_ADDR + 4n. A maskable group reads back {0, LV[14:12], 000, IE[8], 000, IR[4], 000, ID[0]}. Group 1, unaligned addresses and addresses outside the bank read 0, and writes to them have no effect.
- R3: bus_be_i[1] enables writes to bits 15:8 (LV, IE) and bus_be_i[0] enables writes to bits 7:0. A lane whose enable is low is left unchanged.
- R4: A rising edge on mreq_i[n] sets IR of group n. Writing 1 to bit 4 with lane 0 enabled clears it. A request held high does not set IR again. A rising edge in the same cycle as a clear leaves IR set.
- R5: ID (bit 0) reads IR AND IE, and a maskable group is pending only when ID is 1.
- R6: A maskable group is signalled only when the global enable is 1 and its LV is strictly less than the mask. Mask 0 blocks every maskable group.
- R7: Among pending groups, the lowest LV wins, and on equal LV the lowest group number wins.
- R8: Group 0 bits 2:0 latch rising edges of nmi_src_i[2:0] and are cleared by writing 1 to them. Any set bit signals group 0 at level 0, whatever the enable and mask, ahead of every maskable group.
- R9: irq_ack_i while irq_valid_o is 1 clears the global enable at the next edge, and wins over a flag write in the same cycle. irq_ack_i while irq_valid_o is 0 has no effect.
- R10: flag_we_i loads flag_ie_i and flag_im_i into the global enable and the mask at the next edge.
- R11: While irq_valid_o is 0, irq_group_o and irq_level_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access select |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | AW (9) | Byte address |
| bus_be_i | input | 2 | Byte lane enables |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data (combinational on address) |
| mreq_i | input | NUM_GRP-2 (18) | Maskable requests, groups 2..NUM_GRP-1 |
| nmi_src_i | input | 3 | Non-maskable sources: external pin, watchdog overflow, system error |
| flag_we_i | input | 1 | Load global enable and mask |
| flag_ie_i | input | 1 | Global enable value to load |
| flag_im_i | input | 3 | Mask level to load |
| cpu_ie_o | output | 1 | Current global enable |
| cpu_im_o | output | 3 | Current mask level |
| irq_ack_i | input | 1 | Processor accepts the signalled interrupt |
| irq_valid_o | output | 1 | Interrupt signalled |
| irq_group_o | output | GW (5) | Group number of the signalled interrupt |
| irq_level_o | output | 3 | Level of the signalled interrupt |

## Verification
The flag-load property assumes that a flag write which coincides with an accepted acknowledge loses only the enable bit. The bench therefore never raises flag_we_i and irq_ack_i together, except where it checks that precedence on purpose. The non-maskable latch property assumes software does not clear a source in the cycle it is raised. The stimulus drives every request as a one-cycle pulse followed by a low cycle, and it issues clears only after the pulse has been latched. Bus accesses stay word-aligned, except for the deliberate checks of unaligned and out-of-range addresses.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int LV_W = 3;
  typedef logic [LV_W-1:0] lv_t;
  typedef struct packed {
    lv_t  lv;
    logic ie;
    logic ir;
  } grp_cfg_t;
endpackage

// File: rtl/lvl_irq_edge.sv
module lvl_irq_edge #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/lvl_irq_grp.sv
module lvl_irq_grp import lvl_irq_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [1:0]  be_i,
  input  lv_t         wlv_i,
  input  logic        wie_i,
  input  logic        wir_i,
  input  logic        set_i,
  output grp_cfg_t    cfg_o,
  output logic [15:0] rdata_o
);
  grp_cfg_t q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else begin
      if (wr_i && be_i[1]) begin
        q.lv <= wlv_i;
        q.ie <= wie_i;
      end
      // new edge beats software clear
      if (set_i)                              q.ir <= 1'b1;
      else if (wr_i && be_i[0] && wir_i)      q.ir <= 1'b0;
    end
  end
  assign cfg_o   = q;
  assign rdata_o = {1'b0, q.lv, 3'b000, q.ie, 3'b000, q.ir, 3'b000, q.ir & q.ie};
endmodule

// File: rtl/lvl_irq_arb.sv
module lvl_irq_arb import lvl_irq_pkg::*; #(
  parameter int NUM_GRP = 20,
  parameter int GW      = $clog2(NUM_GRP)
) (
  input  grp_cfg_t        cfg_i [NUM_GRP-1:2],
  output logic            found_o,
  output logic [GW-1:0]   grp_o,
  output lv_t             lv_o
);
  always_comb begin
    found_o = 1'b0;
    grp_o   = '0;
    lv_o    = '0;
    // ascending scan; strict compare keeps lowest index on ties
    for (int g = 2; g < NUM_GRP; g++) begin
      if (cfg_i[g].ie && cfg_i[g].ir && (!found_o || cfg_i[g].lv < lv_o)) begin
        found_o = 1'b1;
        grp_o   = GW'(g);
        lv_o    = cfg_i[g].lv;
      end
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl import lvl_irq_pkg::*; #(
  parameter int NUM_GRP   = 20,
  parameter int NUM_NMI   = 3,
  parameter int AW        = 9,
  parameter int BASE_ADDR = 'h100,
  parameter int GW        = $clog2(NUM_GRP)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_sel_i,
  input  logic               bus_we_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [1:0]         bus_be_i,
  input  logic [15:0]        bus_wdata_i,
  output logic [15:0]        bus_rdata_o,
  input  logic [NUM_GRP-1:2] mreq_i,
  input  logic [NUM_NMI-1:0] nmi_src_i,
  input  logic               flag_we_i,
  input  logic               flag_ie_i,
  input  logic [LV_W-1:0]    flag_im_i,
  output logic               cpu_ie_o,
  output logic [LV_W-1:0]    cpu_im_o,
  input  logic               irq_ack_i,
  output logic               irq_valid_o,
  output logic [GW-1:0]      irq_group_o,
  output logic [LV_W-1:0]    irq_level_o
);
  localparam logic [AW-1:0] BASE = AW'(BASE_ADDR);

  // address decode
  logic [AW-1:0] off;
  logic [GW-1:0] idx;
  logic          hit, wr;
  assign off = bus_addr_i - BASE;
  assign idx = off[GW+1:2];
  assign hit = (bus_addr_i >= BASE) && (off[1:0] == 2'b00) &&
               (32'(off[AW-1:2]) < NUM_GRP);
  assign wr  = bus_sel_i && bus_we_i && hit;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata_i[15], bus_wdata_i[11:9], bus_wdata_i[7:5], bus_wdata_i[3]};

  // request edges
  logic [NUM_GRP-1:2] mrise;
  logic [NUM_NMI-1:0] nrise;
  lvl_irq_edge #(.W(NUM_GRP-2)) u_medge (.clk_i, .rst_ni, .sig_i(mreq_i),    .rise_o(mrise));
  lvl_irq_edge #(.W(NUM_NMI))   u_nedge (.clk_i, .rst_ni, .sig_i(nmi_src_i), .rise_o(nrise));

  // maskable group registers
  grp_cfg_t    cfg    [NUM_GRP-1:2];
  logic [15:0] rd_arr [NUM_GRP];

  for (genvar g = 2; g < NUM_GRP; g++) begin : g_grp
    lvl_irq_grp u_grp (
      .clk_i, .rst_ni,
      .wr_i   (wr && (idx == GW'(g))),
      .be_i   (bus_be_i),
      .wlv_i  (bus_wdata_i[14:12]),
      .wie_i  (bus_wdata_i[8]),
      .wir_i  (bus_wdata_i[4]),
      .set_i  (mrise[g]),
      .cfg_o  (cfg[g]),
      .rdata_o(rd_arr[g])
    );
  end

  // non-maskable group 0
  logic [NUM_NMI-1:0] nmi_q;
  logic               nmi_clr_en;
  assign nmi_clr_en = wr && (idx == '0) && bus_be_i[0];
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) nmi_q <= '0;
    else         nmi_q <= nrise | (nmi_q & ~({NUM_NMI{nmi_clr_en}} & bus_wdata_i[NUM_NMI-1:0]));

  assign rd_arr[0]   = 16'(nmi_q);
  assign rd_arr[1]   = '0;
  assign bus_rdata_o = hit ? rd_arr[idx] : '0;

  // arbitration
  logic          found;
  logic [GW-1:0] best_grp;
  lv_t           best_lv;
  lvl_irq_arb #(.NUM_GRP(NUM_GRP), .GW(GW)) u_arb (
    .cfg_i(cfg), .found_o(found), .grp_o(best_grp), .lv_o(best_lv)
  );

  // processor flags
  logic ie_q;
  lv_t  im_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q <= 1'b0;
      im_q <= '0;
    end else begin
      if (irq_ack_i && irq_valid_o) ie_q <= 1'b0;
      else if (flag_we_i)           ie_q <= flag_ie_i;
      if (flag_we_i)                im_q <= flag_im_i;
    end
  end
  assign cpu_ie_o = ie_q;
  assign cpu_im_o = im_q;

  // request to processor
  logic nmi_pend, mask_ok;
  assign nmi_pend    = |nmi_q;
  assign mask_ok     = found && ie_q && (best_lv < im_q);
  assign irq_valid_o = nmi_pend || mask_ok;
  assign irq_group_o = nmi_pend ? '0 : (mask_ok ? best_grp : '0);
  assign irq_level_o = nmi_pend ? '0 : (mask_ok ? best_lv  : '0);
endmodule

// File: rtl/lvl_irq_chk.sv
module lvl_irq_chk #(
  parameter int NUM_GRP = 20,
  parameter int NUM_NMI = 3,
  parameter int GW      = $clog2(NUM_GRP)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_NMI-1:0] nmi_src_i,
  input logic               flag_we_i,
  input logic               flag_ie_i,
  input logic [2:0]         flag_im_i,
  input logic               cpu_ie_o,
  input logic [2:0]         cpu_im_o,
  input logic               irq_ack_i,
  input logic               irq_valid_o,
  input logic [GW-1:0]      irq_group_o,
  input logic [2:0]         irq_level_o
);
  a_r9_ack_clears_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i && irq_valid_o |=> !cpu_ie_o);

  a_r10_flag_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && !(irq_ack_i && irq_valid_o) |=>
      cpu_ie_o == $past(flag_ie_i) && cpu_im_o == $past(flag_im_i));

  a_r6_mask_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o && irq_group_o != '0 |-> cpu_ie_o && irq_level_o < cpu_im_o);

  a_r8_nmi_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_src_i[0]) |=> irq_valid_o && irq_group_o == '0 && irq_level_o == '0);

  a_r11_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_valid_o |-> irq_group_o == '0 && irq_level_o == '0);

  a_r2_group_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> irq_group_o != GW'(1) && 32'(irq_group_o) < NUM_GRP);
endmodule

bind lvl_irq_ctrl lvl_irq_chk #(.NUM_GRP(NUM_GRP), .NUM_NMI(NUM_NMI), .GW(GW)) u_chk (.*);

// File: tb/tb_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module tb_lvl_irq_ctrl;
  localparam int NUM_GRP = 20;
  localparam int AW      = 9;
  localparam int GW      = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0] bus_be = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [NUM_GRP-1:2] mreq = '0;
  logic [2:0] nmi_src = '0;
  logic flag_we = 0, flag_ie = 0;
  logic [2:0] flag_im = '0;
  logic cpu_ie;
  logic [2:0] cpu_im;
  logic ack = 0;
  logic irq_valid;
  logic [GW-1:0] irq_group;
  logic [2:0] irq_level;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lvl_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(bus_sel), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_be_i(bus_be), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .mreq_i(mreq), .nmi_src_i(nmi_src),
    .flag_we_i(flag_we), .flag_ie_i(flag_ie), .flag_im_i(flag_im),
    .cpu_ie_o(cpu_ie), .cpu_im_o(cpu_im), .irq_ack_i(ack),
    .irq_valid_o(irq_valid), .irq_group_o(irq_group), .irq_level_o(irq_level)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [AW-1:0] ga(int g);
    return AW'('h100 + 4*g);
  endfunction

  function automatic logic [15:0] rv(int lv, int ie, int ir);
    return 16'((lv << 12) | (ie << 8) | (ir << 4) | (ie & ir));
  endfunction

  task automatic wr(logic [AW-1:0] a, logic [15:0] d, logic [1:0] be);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    step();
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic setf(logic ie, logic [2:0] im);
    flag_we = 1; flag_ie = ie; flag_im = im;
    step();
    flag_we = 0;
  endtask

  task automatic pulse(int g);
    mreq[g] = 1; step(); mreq[g] = 0; step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    @(negedge clk); @(negedge clk);
    rst_n = 1; @(negedge clk);

    // R1 reset state
    chk("R1 ie", 32'(cpu_ie), 0);
    chk("R1 im", 32'(cpu_im), 0);
    chk("R1 valid", 32'(irq_valid), 0);
    rd(ga(0), d); chk("R1 grp0", 32'(d), 0);
    for (int g = 2; g < NUM_GRP; g++) begin rd(ga(g), d); chk("R1 grp", 32'(d), 0); end

    // R2 layout and decode
    wr(ga(2), 16'hFFFF, 2'b11); rd(ga(2), d); chk("R2 layout", 32'(d), 32'h7100);
    wr(ga(1), 16'hFFFF, 2'b11); rd(ga(1), d); chk("R2 group1", 32'(d), 0);
    rd(AW'('h150), d); chk("R2 out of range", 32'(d), 0);
    rd(AW'('h109), d); chk("R2 unaligned", 32'(d), 0);
    rd(AW'('h0FC), d); chk("R2 below base", 32'(d), 0);
    for (int g = 2; g < NUM_GRP; g++) wr(ga(g), rv(g % 8, g % 2, 0), 2'b11);
    for (int g = 2; g < NUM_GRP; g++) begin rd(ga(g), d); chk("R2 readback", 32'(d), 32'(rv(g % 8, g % 2, 0))); end
    for (int g = 2; g < NUM_GRP; g++) wr(ga(g), 16'h0, 2'b11);

    // R3 byte lanes
    wr(ga(4), 16'h5100, 2'b10); rd(ga(4), d); chk("R3 high lane", 32'(d), 32'h5100);
    wr(ga(4), 16'h0000, 2'b01); rd(ga(4), d); chk("R3 low lane keeps high", 32'(d), 32'h5100);
    wr(ga(4), 16'h0000, 2'b00); rd(ga(4), d); chk("R3 no lane", 32'(d), 32'h5100);
    wr(ga(4), 16'h0000, 2'b10); rd(ga(4), d); chk("R3 clear high", 32'(d), 0);

    // R4 / R5 request latch and detect
    wr(ga(6), rv(2, 1, 0), 2'b11);
    mreq[6] = 1; step();
    rd(ga(6), d); chk("R4 R5 rise sets IR, ID", 32'(d), 32'(rv(2, 1, 1)));
    wr(ga(6), 16'h0010, 2'b01); step();
    rd(ga(6), d); chk("R4 held no reset", 32'(d), 32'(rv(2, 1, 0)));
    mreq[6] = 0; step();
    mreq[6] = 1; bus_sel = 1; bus_we = 1; bus_addr = ga(6); bus_wdata = 16'h0010; bus_be = 2'b01;
    step(); bus_sel = 0; bus_we = 0; mreq[6] = 0;
    rd(ga(6), d); chk("R4 set beats clear", 32'(d), 32'(rv(2, 1, 1)));
    wr(ga(6), 16'h2000, 2'b10); rd(ga(6), d); chk("R5 ID needs IE", 32'(d), 32'(rv(2, 0, 1)));
    setf(1, 3'd7); chk("R5 not pending w/o ID", 32'(irq_valid), 0);
    wr(ga(6), 16'h0010, 2'b11); rd(ga(6), d); chk("R4 w1c", 32'(d), 0);
    step(); // mreq low cycle seen

    // R6 mask sweep on group 5
    wr(ga(5), rv(0, 1, 0), 2'b11); pulse(5);
    for (int im = 0; im < 8; im++)
      for (int lv = 0; lv < 8; lv++) begin
        wr(ga(5), rv(lv, 1, 0), 2'b10); setf(1, 3'(im));
        chk("R6 valid", 32'(irq_valid), 32'(lv < im));
        chk("R6 R11 group", 32'(irq_group), (lv < im) ? 5 : 0);
        chk("R6 R11 level", 32'(irq_level), (lv < im) ? 32'(lv) : 0);
      end
    setf(0, 3'd7); chk("R6 ie off blocks", 32'(irq_valid), 0);
    chk("R10 flags loaded", 32'({cpu_ie, cpu_im}), 32'h7);
    wr(ga(5), 16'h0010, 2'b11);

    // R7 arbitration sweep, groups 3 and 7
    wr(ga(3), rv(0, 1, 0), 2'b11); wr(ga(7), rv(0, 1, 0), 2'b11);
    pulse(3); pulse(7); setf(1, 3'd7);
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        int eg, el;
        wr(ga(3), rv(a, 1, 0), 2'b10); wr(ga(7), rv(b, 1, 0), 2'b10);
        eg = (a <= b) ? 3 : 7; el = (a <= b) ? a : b;
        if (el >= 7) begin eg = 0; el = 0; end
        chk("R7 valid", 32'(irq_valid), 32'(eg != 0));
        chk("R7 group", 32'(irq_group), 32'(eg));
        chk("R7 level", 32'(irq_level), 32'(el));
      end

    // R8 NMI beats everything, ignores flags
    wr(ga(3), rv(0, 1, 0), 2'b10);
    setf(0, 3'd0);
    nmi_src[1] = 1; step(); nmi_src[1] = 0; step();
    chk("R8 nmi valid", 32'(irq_valid), 1);
    chk("R8 nmi group", 32'(irq_group), 0);
    chk("R8 nmi level", 32'(irq_level), 0);
    rd(ga(0), d); chk("R8 grp0 read", 32'(d), 32'h2);
    setf(1, 3'd7); chk("R8 nmi beats level0", 32'(irq_group), 0);
    nmi_src[2] = 1; step(); nmi_src[2] = 0; step();
    wr(ga(0), 16'h0002, 2'b01); rd(ga(0), d); chk("R8 w1c", 32'(d), 32'h4);
    wr(ga(0), 16'h0004, 2'b01);
    chk("R8 cleared -> maskable", 32'(irq_group), 3);

    // R9 acknowledge
    ack = 1; step(); ack = 0;
    chk("R9 ack clears ie", 32'(cpu_ie), 0);
    chk("R9 mask kept", 32'(cpu_im), 7);
    chk("R9 blocked after ack", 32'(irq_valid), 0);
    flag_we = 1; flag_ie = 1; flag_im = 3'd5; step(); // no valid at this point? ie=0 => none
    flag_we = 0;
    chk("R10 load ie", 32'(cpu_ie), 1);
    flag_we = 1; flag_ie = 1; flag_im = 3'd6; ack = 1; step(); flag_we = 0; ack = 0;
    chk("R9 ack beats flag write", 32'(cpu_ie), 0);
    chk("R10 im still loads", 32'(cpu_im), 6);
    wr(ga(3), 16'h0010, 2'b11); wr(ga(7), 16'h0010, 2'b11);
    setf(1, 3'd7);
    ack = 1; step(); ack = 0;
    chk("R9 ack w/o valid ignored", 32'(cpu_ie), 1);
    chk("R11 idle group", 32'(irq_group), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule